// File: doc/BRIEF.md
# Peripheral Chip-Select Decoder

This block turns a latched bus address into seven active-low select lines, each one owning a 256-byte window. The seven windows sit back to back above a programmable base, which is always aligned to 256 bytes. The window group belongs either to I/O space or to memory space, as set by a configuration bit. Each bus cycle carries a space flag. A select fires only when the latched address falls inside the group and the cycle's space flag matches the configured space.

The address and its space flag are captured on the clock edge where the address-latch strobe is high. The selects are decoded from that captured copy, so they stay steady through the data phase of the cycle. The seventh select has no pin of its own. It shares one output with the captured address bit 2. A mode input chooses between the two: with the mode bit at 1 the pin carries select 6, and with it at 0 the pin carries the address bit.

While the bus is held by another master, or while reset is applied, every select is driven inactive high. During a hold, strobes are not accepted. In address-bit mode the shared pin keeps showing the bit it last captured.

Top module: `periph_sel_decode`

## Requirements
- R1: While `rstN` is low, `selN` and `sharedPin` are all 1. After reset, no select goes low until an address has been captured.
- R2: An address and space flag are captured only on a rising clock edge with `addrStrobe` = 1 and `busHold` = 0. The new decode is visible right after that edge. Changing `addrIn` or `spaceIsIo` without a strobe has no effect on the outputs.
- R3: The base is `baseHi` × 256. Select i (0 to 5 on `selN[i]`, 6 on `sharedPin` when `extMode` = 1) is low exactly when the captured address lies in base + 256·i through base + 256·i + 255.
- R4: A captured address below the base, or at base + 7·256 or above, drives no select low. Offsets do not wrap around the top of the address range.
- R5: A select fires only when the captured space flag (1 = I/O, 0 = memory) equals `cfgSpaceIo`.
- R6: At most one of the seven selects is low at any time.
- R7: With `extMode` = 0, `sharedPin` carries captured address bit 2 and the region-6 decode is not driven out. `selN[5:0]` behave as in R3.
- R8: While `busHold` = 1, all `selN` are 1. With `extMode` = 1, `sharedPin` is also 1.
- R9: While `busHold` = 1, strobes are ignored. With `extMode` = 0, `sharedPin` keeps its captured address bit throughout the hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | 20 | Bus address |
| addrStrobe | input | 1 | Address-latch strobe, sampled on the clock edge |
| spaceIsIo | input | 1 | Space flag of the current cycle: 1 = I/O, 0 = memory |
| baseHi | input | 12 | Group base address divided by 256 |
| cfgSpaceIo | input | 1 | Space the group lives in: 1 = I/O, 0 = memory |
| extMode | input | 1 | 1: shared pin is select 6; 0: shared pin is address bit 2 |
| busHold | input | 1 | Bus held by another master |
| selN | output | 6 | Active-low selects for regions 0 to 5 |
| sharedPin | output | 1 | Select 6 (active low) or captured address bit 2 |

## Verification
The decode is driven with addresses at the first and last byte of several windows, just below the base, and just past the seventh window. This separates an off-by-one window edge from a wrong region index. Bases at zero and at the very top of the range expose any wrap-around in the offset arithmetic. Matched and mismatched space flags under both space settings show that the space check compares the two bits rather than trusting either one. Addresses with bit 2 set and clear, in both modes and during holds, tell the select path on the shared pin apart from the frozen address bit.

// File: rtl/psel_pkg.sv
package psel_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load address and space flag this edge
    logic selOff;    // force selects 0..5 inactive
    logic pinOff;    // force shared pin high
    logic showAddr;  // shared pin carries latched address bit
  } psel_strobe_t;

endpackage

// File: rtl/psel_ctrl.sv
module psel_ctrl
  import psel_pkg::*;
(
  input  logic         rstN,
  input  logic         addrStrobe,
  input  logic         busHold,
  input  logic         extMode,
  output psel_strobe_t strb
);

  always_comb begin
    strb.capture  = addrStrobe & ~busHold;
    strb.selOff   = ~rstN | busHold;
    // in address-bit mode the pin keeps its value through a hold
    strb.pinOff   = ~rstN | (busHold & extMode);
    strb.showAddr = ~extMode;
  end

endmodule

// File: rtl/psel_datapath.sv
module psel_datapath
  import psel_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int REGION_BITS = 8,
  parameter int NUM_SEL     = 7,
  parameter int SHARED_BIT  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  psel_strobe_t                  strb,
  input  logic [ADDR_W-1:0]             addrIn,
  input  logic                          spaceIsIo,
  input  logic [ADDR_W-REGION_BITS-1:0] baseHi,
  input  logic                          cfgSpaceIo,
  output logic [NUM_SEL-2:0]            selN,
  output logic                          sharedPin
);

  localparam int IDX_W = ADDR_W - REGION_BITS;

  logic [ADDR_W-1:0] addrQ;
  logic              spaceQ;
  logic              validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      spaceQ <= 1'b0;
      validQ <= 1'b0;
    end else if (strb.capture) begin
      addrQ  <= addrIn;
      spaceQ <= spaceIsIo;
      validQ <= 1'b1;
    end
  end

  // Offset with a borrow bit so addresses below the base never wrap in
  logic [ADDR_W:0]  diff;
  logic             borrow;
  logic [IDX_W-1:0] regionIdx;
  logic             inGroup;

  always_comb begin
    diff      = {1'b0, addrQ} - {1'b0, baseHi, {REGION_BITS{1'b0}}};
    borrow    = diff[ADDR_W];
    regionIdx = diff[ADDR_W-1:REGION_BITS];
    inGroup   = validQ & ~borrow & (spaceQ == cfgSpaceIo)
              & (regionIdx < IDX_W'(NUM_SEL));
  end

  logic [NUM_SEL-1:0] regionHit;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_region
    assign regionHit[i] = inGroup & (regionIdx == IDX_W'(i));
  end

  for (genvar i = 0; i < NUM_SEL - 1; i++) begin : g_sel
    assign selN[i] = ~(regionHit[i] & ~strb.selOff);
  end

  always_comb begin
    if (strb.pinOff)        sharedPin = 1'b1;
    else if (strb.showAddr) sharedPin = addrQ[SHARED_BIT];
    else                    sharedPin = ~regionHit[NUM_SEL-1];
  end

endmodule

// File: rtl/periph_sel_decode.sv
module periph_sel_decode
  import psel_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int REGION_BITS = 8,
  parameter int NUM_SEL     = 7,
  parameter int SHARED_BIT  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             addrIn,
  input  logic                          addrStrobe,
  input  logic                          spaceIsIo,
  input  logic [ADDR_W-REGION_BITS-1:0] baseHi,
  input  logic                          cfgSpaceIo,
  input  logic                          extMode,
  input  logic                          busHold,
  output logic [NUM_SEL-2:0]            selN,
  output logic                          sharedPin
);

  psel_strobe_t strb;

  psel_ctrl u_ctrl (
    .rstN      (rstN),
    .addrStrobe(addrStrobe),
    .busHold   (busHold),
    .extMode   (extMode),
    .strb      (strb)
  );

  psel_datapath #(
    .ADDR_W     (ADDR_W),
    .REGION_BITS(REGION_BITS),
    .NUM_SEL    (NUM_SEL),
    .SHARED_BIT (SHARED_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addrIn    (addrIn),
    .spaceIsIo (spaceIsIo),
    .baseHi    (baseHi),
    .cfgSpaceIo(cfgSpaceIo),
    .selN      (selN),
    .sharedPin (sharedPin)
  );

endmodule

// File: rtl/psel_checker.sv
module psel_checker #(
  parameter int NUM_SEL = 7,
  parameter int BASE_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               addrStrobe,
  input logic               busHold,
  input logic               extMode,
  input logic               cfgSpaceIo,
  input logic [BASE_W-1:0]  baseHi,
  input logic [NUM_SEL-2:0] selN,
  input logic               sharedPin
);

  logic [NUM_SEL-1:0] allSelN;
  assign allSelN = {extMode ? sharedPin : 1'b1, selN};

  // R1: everything inactive while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (&selN && sharedPin));

  // R2: without a strobe and with steady configuration the selects hold
  p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !addrStrobe ##1 ($stable(baseHi) && $stable(cfgSpaceIo) &&
                     $stable(extMode) && $stable(busHold))
    |-> ($stable(selN) && $stable(sharedPin)));

  // R6: never two selects at once
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~allSelN));

  // R8: bus hold silences every select
  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    busHold |-> (&allSelN));

  // R9: address bit frozen across a hold in address-bit mode
  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busHold && !extMode) |=> (!busHold || extMode || $stable(sharedPin)));

endmodule

bind periph_sel_decode psel_checker #(
  .NUM_SEL(NUM_SEL),
  .BASE_W (ADDR_W - REGION_BITS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addrStrobe(addrStrobe),
  .busHold   (busHold),
  .extMode   (extMode),
  .cfgSpaceIo(cfgSpaceIo),
  .baseHi    (baseHi),
  .selN      (selN),
  .sharedPin (sharedPin)
);

// File: tb/periph_sel_decode_bench.sv
`timescale 1ns/1ps
module periph_sel_decode_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addrIn = '0;
  logic        addrStrobe = 1'b0;
  logic        spaceIsIo = 1'b1;
  logic [11:0] baseHi = 12'h012;
  logic        cfgSpaceIo = 1'b1;
  logic        extMode = 1'b1;
  logic        busHold = 1'b0;
  logic [5:0]  selN;
  logic        sharedPin;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  periph_sel_decode u_periph_sel_decode (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrStrobe(addrStrobe),
    .spaceIsIo(spaceIsIo), .baseHi(baseHi), .cfgSpaceIo(cfgSpaceIo),
    .extMode(extMode), .busHold(busHold), .selN(selN), .sharedPin(sharedPin)
  );

  // {baseHi, addr, spaceIsIo, cfgSpaceIo, extMode, expected {pin, selN}}
  localparam int NV = 16;
  localparam logic [41:0] VEC [NV] = '{
    {12'h012, 20'h01200, 3'b111, 7'h7E},  // R3 first byte region 0
    {12'h012, 20'h012FF, 3'b111, 7'h7E},  // R3 last byte region 0
    {12'h012, 20'h01300, 3'b111, 7'h7D},  // R3 region 1
    {12'h012, 20'h01555, 3'b111, 7'h77},  // R3 region 3
    {12'h012, 20'h01600, 3'b111, 7'h6F},  // R3 region 4
    {12'h012, 20'h017FF, 3'b111, 7'h5F},  // R3 region 5 last byte
    {12'h012, 20'h01800, 3'b111, 7'h3F},  // R3 region 6 on shared pin
    {12'h012, 20'h01900, 3'b111, 7'h7F},  // R4 past seventh window
    {12'h012, 20'h011FF, 3'b111, 7'h7F},  // R4 one below base
    {12'h012, 20'h01200, 3'b011, 7'h7F},  // R5 memory cycle, I/O group
    {12'h012, 20'h01200, 3'b001, 7'h7E},  // R5 memory group matches
    {12'h012, 20'h01804, 3'b110, 7'h7F},  // R7 region 6 hidden, bit2=1
    {12'h012, 20'h01300, 3'b110, 7'h3D},  // R7 region 1, bit2=0
    {12'hFFF, 20'hFFF05, 3'b111, 7'h7E},  // R3 base at top
    {12'hFFF, 20'h00000, 3'b111, 7'h7F},  // R4 no wrap
    {12'h000, 20'h00604, 3'b111, 7'h3F}   // R3 base zero region 6
  };

  bit done = 1'b0;

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {sharedPin, selN};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample just after it
  task automatic latch(input logic [19:0] a, input logic io, input logic stb);
    @(negedge clk);
    addrIn = a; spaceIsIo = io; addrStrobe = stb;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    addrStrobe = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state in both modes
    repeat (2) @(posedge clk); #1;
    check("R1 reset select mode", 7'h7F);
    extMode = 1'b0; #1;
    check("R1 reset addr mode", 7'h7F);
    @(negedge clk); rstN = 1'b1; extMode = 1'b1;
    @(posedge clk); #1;
    check("R1 no select before capture", 7'h7F);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      baseHi = VEC[i][41:30];
      cfgSpaceIo = VEC[i][8];
      extMode = VEC[i][7];
      latch(VEC[i][29:10], VEC[i][9], 1'b1);
      check($sformatf("R3/R4/R5/R7 vector %0d", i), VEC[i][6:0]);
      idle();
    end

    // R2: address change without strobe ignored
    baseHi = 12'h012; cfgSpaceIo = 1'b1; extMode = 1'b1;
    latch(20'h01300, 1'b1, 1'b1);
    check("R2 captured", 7'h7D);
    latch(20'h01600, 1'b1, 1'b0);
    check("R2 no strobe", 7'h7D);
    latch(20'h01600, 1'b0, 1'b0);
    check("R2 space change no strobe", 7'h7D);

    // R8/R9 select mode hold
    @(negedge clk); busHold = 1'b1;
    @(posedge clk); #1;
    check("R8 hold select mode", 7'h7F);
    latch(20'h01804, 1'b1, 1'b1);
    check("R8 hold strobe", 7'h7F);
    @(negedge clk); busHold = 1'b0; addrStrobe = 1'b0;
    @(posedge clk); #1;
    check("R9 strobe ignored in hold", 7'h7D);

    // R9 address mode hold
    extMode = 1'b0;
    latch(20'h01304, 1'b1, 1'b1);
    check("R7 addr mode bit2=1", 7'h7D);
    @(negedge clk); busHold = 1'b1; addrStrobe = 1'b0;
    @(posedge clk); #1;
    check("R9 pin frozen in hold", 7'h7F);
    latch(20'h01300, 1'b1, 1'b1);
    check("R9 pin frozen after strobe", 7'h7F);
    @(negedge clk); busHold = 1'b0; addrStrobe = 1'b0;
    @(posedge clk); #1;
    check("R9 address kept after hold", 7'h7D);
    latch(20'h01300, 1'b1, 1'b1);
    check("R7 new bit2=0", 7'h3D);
    idle();

    // R1: reset mid-run forces everything high again
    extMode = 1'b1;
    latch(20'h01800, 1'b1, 1'b1);
    check("R3 region 6 before reset", 7'h3F);
    @(negedge clk); rstN = 1'b0; addrStrobe = 1'b0; #1;
    check("R1 async reset", 7'h7F);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 capture cleared", 7'h7F);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule